// File: doc/BRIEF.md
# Breakpoint Address Match Table

This block keeps a small, dense table of instruction breakpoints for a debug unit. Each slot holds a 32-bit instruction address and a kind: a kept breakpoint stays in the table after it fires, and a once breakpoint is removed when it fires. A command port adds entries, removes entries, and looks up the kind stored for an address. A separate fetch-compare port reports, in the same cycle, whether the current program counter matches a stored entry.

New entries go at the end of the occupied region. A removal closes the gap by moving each later entry down one slot, one slot per cycle. While this compaction runs, the command port holds ready low and the fetch compare reports no hit. Whenever the table content changes, the block pulses an invalidate strobe that carries the affected address. A downstream instruction cache or translation store can then drop stale copies.

The controller has two states. IDLE accepts commands and evaluates fetch matches. COMPACT moves one entry per cycle. There are two transitions. IDLE goes to COMPACT on a removal whose slot is not the last occupied one (remove-with-gap). COMPACT goes back to IDLE on the cycle that moves the last entry (gap-closed). A removal of the last occupied slot stays in IDLE and only decrements the count.

Top module: `brkpt_table`

## Requirements
- R1: After reset, entry_count is 0, cmd_ready is 1, and bp_hit, rsp_valid and inval_valid are 0.
- R2: An accepted add (cmd_op 0) on a table that is not full stores cmd_addr and cmd_kind (0 = kept, 1 = once) in slot entry_count and increments entry_count. In the next cycle it gives rsp_ok 1 and an inval_valid pulse with inval_addr equal to the added address.
- R3: An add on a full table (entry_count equal to DEPTH) gives rsp_ok 0 and no invalidate pulse, and it leaves the table and entry_count unchanged.
- R4: An accepted remove (cmd_op 1) deletes the lowest slot whose address and kind both match. Later entries keep their order, and entry_count drops by one. The next cycle gives rsp_ok 1 and an invalidate pulse with that address.
- R5: A remove with no entry matching both address and kind gives rsp_ok 0 and no invalidate pulse, and it leaves the table unchanged.
- R6: An accepted lookup (cmd_op 2) returns in rsp_kind the code of the lowest slot whose address matches, whatever its kind. The codes are 2'b01 for kept, 2'b10 for once and 2'b00 (none) for no match. rsp_ok is 1 exactly when a match exists.
- R7: A removal from slot k when n entries are held keeps cmd_ready low for exactly n-1-k cycles after the removal edge. Commands, including lookups, stall until compaction ends.
- R8: In IDLE with pc_valid high, bp_hit is 1 in the same cycle when pc_addr matches a stored address. bp_kind then gives the code (as in R6) of the lowest matching slot.
- R9: A fetch match on a once entry takes priority over the command port: cmd_ready is low in that cycle. At the clock edge the entry is removed as in R4, and an invalidate pulse with pc_addr follows.
- R10: During compaction bp_hit stays 0.
- R11: Every accepted command gives exactly one rsp_valid pulse in the following cycle and none at other times. cmd_op 3 gives rsp_ok 0 and rsp_kind 2'b00 and changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command request |
| cmd_ready | output | 1 | Command can be taken this cycle |
| cmd_op | input | 2 | 0 add, 1 remove, 2 lookup, 3 no-op |
| cmd_addr | input | AW | Breakpoint address |
| cmd_kind | input | 1 | 0 kept, 1 once |
| rsp_valid | output | 1 | Response pulse |
| rsp_ok | output | 1 | Command succeeded or lookup found |
| rsp_kind | output | 2 | Lookup result code |
| pc_valid | input | 1 | Fetch address present |
| pc_addr | input | AW | Fetch address |
| bp_hit | output | 1 | Fetch address matches an entry |
| bp_kind | output | 2 | Code of the matching entry |
| inval_valid | output | 1 | Invalidate pulse |
| inval_addr | output | AW | Address to invalidate |
| entry_count | output | $clog2(DEPTH+1) | Number of occupied slots |

## Verification
The bench builds the table with DEPTH 4. Random traffic drawn from a pool of five addresses therefore fills the table often. This exercises refused adds, duplicate addresses of both kinds, removals from every slot, and compaction runs of zero to three moves. The bench counts the stall length of every removal and compares it with n-1-k. A directed case probes the fetch port during compaction to check that no hit is reported there.

// File: rtl/brkpt_pkg.sv
package brkpt_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_DEL  = 2'd1,
        OP_LOOK = 2'd2,
        OP_NOP  = 2'd3
    } bp_op_e;

    typedef enum logic {
        KIND_KEEP = 1'b0,
        KIND_ONCE = 1'b1
    } bp_kind_e;

    localparam logic [1:0] LK_NONE = 2'b00;
    localparam logic [1:0] LK_KEEP = 2'b01;
    localparam logic [1:0] LK_ONCE = 2'b10;

    function automatic logic [1:0] kind_code(bp_kind_e k);
        return (k == KIND_ONCE) ? LK_ONCE : LK_KEEP;
    endfunction

endpackage

// File: rtl/bpt_store.sv
module bpt_store
    import brkpt_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            wr_en,
    input  logic [AW-1:0]   wr_addr,
    input  bp_kind_e        wr_kind,
    input  logic            sh_en,
    input  logic [IW-1:0]   sh_idx,
    input  logic            dec_en,
    output logic [AW-1:0]   addr_tab [DEPTH],
    output bp_kind_e        kind_tab [DEPTH],
    output logic [CW-1:0]   count
);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        if (i < DEPTH - 1) begin : g_mov
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_tab[i] <= '0;
                    kind_tab[i] <= KIND_KEEP;
                end else if (wr_en && count == CW'(i)) begin
                    addr_tab[i] <= wr_addr;
                    kind_tab[i] <= wr_kind;
                end else if (sh_en && sh_idx == IW'(i)) begin
                    addr_tab[i] <= addr_tab[i+1];
                    kind_tab[i] <= kind_tab[i+1];
                end
            end
        end else begin : g_top
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    addr_tab[i] <= '0;
                    kind_tab[i] <= KIND_KEEP;
                end else if (wr_en && count == CW'(i)) begin
                    addr_tab[i] <= wr_addr;
                    kind_tab[i] <= wr_kind;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (wr_en)  count <= count + CW'(1);
        else if (dec_en) count <= count - CW'(1);
    end

endmodule

// File: rtl/bpt_match.sv
module bpt_match
    import brkpt_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic [AW-1:0]   addr_tab [DEPTH],
    input  bp_kind_e        kind_tab [DEPTH],
    input  logic [CW-1:0]   count,
    input  logic [AW-1:0]   key_addr,
    input  bp_kind_e        key_kind,
    output logic            addr_hit,
    output logic [IW-1:0]   addr_idx,
    output logic            both_hit,
    output logic [IW-1:0]   both_idx
);

    logic [DEPTH-1:0] am;
    logic [DEPTH-1:0] bm;

    for (genvar i = 0; i < DEPTH; i++) begin : g_cmp
        assign am[i] = (count > CW'(i)) && (addr_tab[i] == key_addr);
        assign bm[i] = am[i] && (kind_tab[i] == key_kind);
    end

    // lowest matching slot wins
    always_comb begin
        addr_idx = '0;
        both_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (am[i]) addr_idx = IW'(i);
            if (bm[i]) both_idx = IW'(i);
        end
    end

    assign addr_hit = |am;
    assign both_hit = |bm;

endmodule

// File: rtl/bpt_ctrl.sv
module bpt_ctrl
    import brkpt_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    input  bp_op_e          cmd_op,
    input  logic [AW-1:0]   cmd_addr,
    output logic            cmd_ready,
    input  logic            pc_valid,
    input  logic [AW-1:0]   pc_addr,
    input  logic            pc_hit,
    input  logic [IW-1:0]   pc_idx,
    input  bp_kind_e        pc_kind,
    input  logic            c_addr_hit,
    input  bp_kind_e        c_addr_kind,
    input  logic            c_both_hit,
    input  logic [IW-1:0]   c_both_idx,
    input  logic [CW-1:0]   count,
    output logic            bp_hit,
    output logic [1:0]      bp_kind,
    output logic            wr_en,
    output logic            sh_en,
    output logic [IW-1:0]   sh_idx,
    output logic            dec_en,
    output logic            busy,
    output logic            rsp_valid,
    output logic            rsp_ok,
    output logic [1:0]      rsp_kind,
    output logic            inval_valid,
    output logic [AW-1:0]   inval_addr
);

    typedef enum logic {ST_IDLE, ST_COMPACT} st_e;

    st_e             state_q, state_d;
    logic [IW-1:0]   ptr_q, ptr_d;
    logic            idle, once_fire, accept, full;
    logic            rm_go;
    logic [IW-1:0]   rm_idx;

    assign idle      = (state_q == ST_IDLE);
    assign busy      = !idle;
    assign bp_hit    = idle && pc_valid && pc_hit;
    assign bp_kind   = bp_hit ? kind_code(pc_kind) : LK_NONE;
    assign once_fire = bp_hit && (pc_kind == KIND_ONCE);
    assign cmd_ready = idle && !once_fire;
    assign accept    = cmd_valid && cmd_ready;
    assign full      = (count == CW'(DEPTH));

    always_comb begin
        rm_go  = 1'b0;
        rm_idx = c_both_idx;
        if (once_fire) begin
            rm_go  = 1'b1;
            rm_idx = pc_idx;
        end else if (accept && cmd_op == OP_DEL && c_both_hit) begin
            rm_go  = 1'b1;
        end
    end

    // next state and table controls
    always_comb begin
        state_d = state_q;
        ptr_d   = ptr_q;
        wr_en   = 1'b0;
        sh_en   = 1'b0;
        sh_idx  = ptr_q;
        dec_en  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                wr_en = accept && (cmd_op == OP_ADD) && !full;
                if (rm_go) begin
                    if ((CW'(rm_idx) + CW'(1)) == count) begin
                        dec_en = 1'b1;
                    end else begin
                        state_d = ST_COMPACT;
                        ptr_d   = rm_idx;
                    end
                end
            end
            ST_COMPACT: begin
                sh_en = 1'b1;
                if ((CW'(ptr_q) + CW'(2)) == count) begin
                    dec_en  = 1'b1;
                    state_d = ST_IDLE;
                end else begin
                    ptr_d = ptr_q + IW'(1);
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
        end
    end

    // registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid   <= 1'b0;
            rsp_ok      <= 1'b0;
            rsp_kind    <= LK_NONE;
            inval_valid <= 1'b0;
            inval_addr  <= '0;
        end else begin
            rsp_valid <= accept;
            rsp_kind  <= LK_NONE;
            rsp_ok    <= 1'b0;
            if (accept) begin
                unique case (cmd_op)
                    OP_ADD:  rsp_ok <= !full;
                    OP_DEL:  rsp_ok <= c_both_hit;
                    OP_LOOK: begin
                        rsp_ok   <= c_addr_hit;
                        rsp_kind <= c_addr_hit ? kind_code(c_addr_kind) : LK_NONE;
                    end
                    default: rsp_ok <= 1'b0;
                endcase
            end
            inval_valid <= once_fire
                        || (accept && cmd_op == OP_ADD && !full)
                        || (accept && cmd_op == OP_DEL && c_both_hit);
            inval_addr  <= once_fire ? pc_addr : cmd_addr;
        end
    end

endmodule

// File: rtl/brkpt_table.sv
module brkpt_table
    import brkpt_pkg::*;
#(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int IW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmd_valid,
    output logic            cmd_ready,
    input  logic [1:0]      cmd_op,
    input  logic [AW-1:0]   cmd_addr,
    input  logic            cmd_kind,
    output logic            rsp_valid,
    output logic            rsp_ok,
    output logic [1:0]      rsp_kind,
    input  logic            pc_valid,
    input  logic [AW-1:0]   pc_addr,
    output logic            bp_hit,
    output logic [1:0]      bp_kind,
    output logic            inval_valid,
    output logic [AW-1:0]   inval_addr,
    output logic [CW-1:0]   entry_count
);

    logic [AW-1:0] addr_tab [DEPTH];
    bp_kind_e      kind_tab [DEPTH];
    logic          wr_en, sh_en, dec_en, busy;
    logic [IW-1:0] sh_idx;
    logic          p_addr_hit, p_both_hit, c_addr_hit, c_both_hit;
    logic [IW-1:0] p_addr_idx, p_both_idx, c_addr_idx, c_both_idx;
    logic          unused_pc_both;

    assign unused_pc_both = ^{p_both_hit, p_both_idx};

    bpt_store #(.AW(AW), .DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (cmd_addr),
        .wr_kind  (bp_kind_e'(cmd_kind)),
        .sh_en    (sh_en),
        .sh_idx   (sh_idx),
        .dec_en   (dec_en),
        .addr_tab (addr_tab),
        .kind_tab (kind_tab),
        .count    (entry_count)
    );

    bpt_match #(.AW(AW), .DEPTH(DEPTH)) u_pc_match (
        .addr_tab (addr_tab),
        .kind_tab (kind_tab),
        .count    (entry_count),
        .key_addr (pc_addr),
        .key_kind (KIND_ONCE),
        .addr_hit (p_addr_hit),
        .addr_idx (p_addr_idx),
        .both_hit (p_both_hit),
        .both_idx (p_both_idx)
    );

    bpt_match #(.AW(AW), .DEPTH(DEPTH)) u_cmd_match (
        .addr_tab (addr_tab),
        .kind_tab (kind_tab),
        .count    (entry_count),
        .key_addr (cmd_addr),
        .key_kind (bp_kind_e'(cmd_kind)),
        .addr_hit (c_addr_hit),
        .addr_idx (c_addr_idx),
        .both_hit (c_both_hit),
        .both_idx (c_both_idx)
    );

    bpt_ctrl #(.AW(AW), .DEPTH(DEPTH)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_op      (bp_op_e'(cmd_op)),
        .cmd_addr    (cmd_addr),
        .cmd_ready   (cmd_ready),
        .pc_valid    (pc_valid),
        .pc_addr     (pc_addr),
        .pc_hit      (p_addr_hit),
        .pc_idx      (p_addr_idx),
        .pc_kind     (kind_tab[p_addr_idx]),
        .c_addr_hit  (c_addr_hit),
        .c_addr_kind (kind_tab[c_addr_idx]),
        .c_both_hit  (c_both_hit),
        .c_both_idx  (c_both_idx),
        .count       (entry_count),
        .bp_hit      (bp_hit),
        .bp_kind     (bp_kind),
        .wr_en       (wr_en),
        .sh_en       (sh_en),
        .sh_idx      (sh_idx),
        .dec_en      (dec_en),
        .busy        (busy),
        .rsp_valid   (rsp_valid),
        .rsp_ok      (rsp_ok),
        .rsp_kind    (rsp_kind),
        .inval_valid (inval_valid),
        .inval_addr  (inval_addr)
    );

endmodule

// File: rtl/bpt_checker.sv
module bpt_checker #(
    parameter int AW    = 32,
    parameter int DEPTH = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cmd_valid,
    input logic            cmd_ready,
    input logic [1:0]      cmd_op,
    input logic [AW-1:0]   cmd_addr,
    input logic            rsp_valid,
    input logic            rsp_ok,
    input logic            bp_hit,
    input logic            inval_valid,
    input logic [AW-1:0]   inval_addr,
    input logic [CW-1:0]   entry_count,
    input logic            busy
);

    AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        entry_count <= CW'(DEPTH)); // R3

    AST_FULL_ADD_REFUSED: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd0 && entry_count == CW'(DEPTH))
        |=> (!rsp_ok && !inval_valid)); // R3

    AST_ADD_INVALIDATES: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && cmd_op == 2'd0 && entry_count < CW'(DEPTH))
        |=> (inval_valid && inval_addr == $past(cmd_addr))); // R2

    AST_RSP_FOLLOWS_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> rsp_valid); // R11

    AST_RSP_HAS_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(cmd_valid && cmd_ready)); // R11

    AST_STALL_WHILE_COMPACT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !cmd_ready); // R7

    AST_NO_HIT_COMPACT: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !bp_hit); // R10

endmodule

bind brkpt_table bpt_checker #(.AW(AW), .DEPTH(DEPTH)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid   (cmd_valid),
    .cmd_ready   (cmd_ready),
    .cmd_op      (cmd_op),
    .cmd_addr    (cmd_addr),
    .rsp_valid   (rsp_valid),
    .rsp_ok      (rsp_ok),
    .bp_hit      (bp_hit),
    .inval_valid (inval_valid),
    .inval_addr  (inval_addr),
    .entry_count (entry_count),
    .busy        (busy)
);

// File: tb/brkpt_table_test.sv
`timescale 1ns/1ps
module brkpt_table_test;

    localparam int AW    = 32;
    localparam int DEPTH = 4;
    localparam int CW    = $clog2(DEPTH + 1);

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            cmd_valid = 1'b0;
    logic            cmd_ready;
    logic [1:0]      cmd_op = 2'd0;
    logic [AW-1:0]   cmd_addr = '0;
    logic            cmd_kind = 1'b0;
    logic            rsp_valid, rsp_ok;
    logic [1:0]      rsp_kind;
    logic            pc_valid = 1'b0;
    logic [AW-1:0]   pc_addr = '0;
    logic            bp_hit;
    logic [1:0]      bp_kind;
    logic            inval_valid;
    logic [AW-1:0]   inval_addr;
    logic [CW-1:0]   entry_count;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    logic [AW-1:0] m_addr [DEPTH];
    logic          m_kind [DEPTH];
    int            m_cnt = 0;

    always #4 clk = ~clk;

    brkpt_table #(.AW(AW), .DEPTH(DEPTH)) uut (.*);

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s act=%0h exp=%0h", req, act, exp);
        end
    endtask

    function automatic int find_both(logic [AW-1:0] a, logic k);
        for (int i = 0; i < m_cnt; i++)
            if (m_addr[i] == a && m_kind[i] == k) return i;
        return -1;
    endfunction

    function automatic int find_addr(logic [AW-1:0] a);
        for (int i = 0; i < m_cnt; i++)
            if (m_addr[i] == a) return i;
        return -1;
    endfunction

    function automatic logic [1:0] code_of(int idx);
        if (idx < 0) return 2'b00;
        return m_kind[idx] ? 2'b10 : 2'b01;
    endfunction

    task automatic m_remove(input int k);
        for (int i = k; i < m_cnt - 1; i++) begin
            m_addr[i] = m_addr[i+1];
            m_kind[i] = m_kind[i+1];
        end
        m_cnt--;
    endtask

    // waits out compaction from a negedge; returns stalled cycles
    task automatic wait_idle(output int n, input bit probe);
        n = 0;
        while (!cmd_ready && n < 20) begin
            if (probe) chk(bp_hit == 1'b0, "R10 hit during compaction", bp_hit, 0);
            n++;
            @(negedge clk);
        end
    endtask

    task automatic do_cmd(input logic [1:0] op, input logic [AW-1:0] a, input logic k,
                          input bit probe, input logic [AW-1:0] pa);
        int ib, ia, moves, n;
        bit exp_ok, exp_inv;
        logic [1:0] exp_kind;
        @(negedge clk);
        cmd_op = op; cmd_addr = a; cmd_kind = k; cmd_valid = 1'b1;
        while (!cmd_ready) @(negedge clk);
        ib = find_both(a, k);
        ia = find_addr(a);
        moves = 0; exp_kind = 2'b00;
        case (op)
            2'd0: begin exp_ok = (m_cnt < DEPTH); exp_inv = exp_ok; end
            2'd1: begin exp_ok = (ib >= 0); exp_inv = exp_ok;
                        if (ib >= 0) moves = m_cnt - 1 - ib; end
            2'd2: begin exp_ok = (ia >= 0); exp_inv = 1'b0; exp_kind = code_of(ia); end
            default: begin exp_ok = 1'b0; exp_inv = 1'b0; end
        endcase
        @(posedge clk); #1;
        cmd_valid = 1'b0;
        if (probe) begin pc_addr = pa; pc_valid = 1'b1; end
        chk(rsp_valid == 1'b1, "R11 rsp pulse", rsp_valid, 1);
        chk(rsp_ok == exp_ok, op == 2'd0 ? (exp_ok ? "R2 add ok" : "R3 full add")
                              : op == 2'd1 ? (exp_ok ? "R4 remove ok" : "R5 remove miss")
                              : op == 2'd2 ? "R6 lookup ok" : "R11 nop ok", rsp_ok, exp_ok);
        chk(rsp_kind == exp_kind, "R6 lookup kind", rsp_kind, exp_kind);
        chk(inval_valid == exp_inv, op == 2'd1 ? "R4 invalidate" : "R2 invalidate",
            inval_valid, exp_inv);
        if (exp_inv) chk(inval_addr == a, "R2 invalidate addr", inval_addr, a);
        if (op == 2'd0 && exp_ok) begin m_addr[m_cnt] = a; m_kind[m_cnt] = k; m_cnt++; end
        if (op == 2'd1 && exp_ok) m_remove(ib);
        @(negedge clk);
        wait_idle(n, probe);
        if (op == 2'd1 && exp_ok) chk(n == moves, "R7 stall cycles", n, moves);
        pc_valid = 1'b0;
        chk(entry_count == CW'(m_cnt), "R4 count", entry_count, m_cnt);
        @(posedge clk); #1;
        chk(rsp_valid == 1'b0, "R11 single pulse", rsp_valid, 0);
    endtask

    task automatic probe_pc(input logic [AW-1:0] a);
        int ia, n, moves;
        @(negedge clk);
        pc_addr = a; pc_valid = 1'b1;
        #1;
        ia = find_addr(a);
        chk(bp_hit == (ia >= 0), "R8 hit", bp_hit, ia >= 0);
        chk(bp_kind == code_of(ia), "R8 kind", bp_kind, code_of(ia));
        if (ia >= 0 && m_kind[ia])
            chk(cmd_ready == 1'b0, "R9 ready low on once hit", cmd_ready, 0);
        @(posedge clk); #1;
        pc_valid = 1'b0;
        if (ia >= 0 && m_kind[ia]) begin
            chk(inval_valid && inval_addr == a, "R9 invalidate", inval_addr, a);
            moves = m_cnt - 1 - ia;
            m_remove(ia);
            @(negedge clk);
            wait_idle(n, 1'b0);
            chk(n == moves, "R9 stall cycles", n, moves);
        end else begin
            chk(inval_valid == 1'b0, "R8 no invalidate", inval_valid, 0);
        end
        @(negedge clk);
        chk(entry_count == CW'(m_cnt), "R9 count", entry_count, m_cnt);
    endtask

    localparam logic [AW-1:0] A0 = 32'h8C00_1000;
    localparam logic [AW-1:0] A1 = 32'h8C00_2004;
    localparam logic [AW-1:0] A2 = 32'h8C00_300A;
    localparam logic [AW-1:0] A3 = 32'h8C00_400E;
    localparam logic [AW-1:0] A4 = 32'h0000_0000;

    function automatic logic [AW-1:0] pick(int i);
        case (i % 5)
            0: return A0;
            1: return A1;
            2: return A2;
            3: return A3;
            default: return A4;
        endcase
    endfunction

    initial begin
        int r;
        void'($urandom(32'h1A2B3C));
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(entry_count == 0, "R1 count", entry_count, 0);
        chk(cmd_ready == 1'b1, "R1 ready", cmd_ready, 1);
        chk(!bp_hit && !rsp_valid && !inval_valid, "R1 quiet",
            {bp_hit, rsp_valid, inval_valid}, 0);

        // fill, overflow, lookups
        do_cmd(2'd0, A0, 1'b0, 0, '0);
        do_cmd(2'd0, A1, 1'b0, 0, '0);
        do_cmd(2'd0, A2, 1'b0, 0, '0);
        do_cmd(2'd0, A3, 1'b0, 0, '0);
        do_cmd(2'd0, A4, 1'b1, 0, '0);           // R3 refused
        do_cmd(2'd2, A2, 1'b0, 0, '0);           // R6
        do_cmd(2'd2, A4, 1'b0, 0, '0);           // R6 none
        do_cmd(2'd1, A1, 1'b1, 0, '0);           // R5 kind mismatch
        do_cmd(2'd3, A1, 1'b0, 0, '0);           // R11 nop
        do_cmd(2'd1, A0, 1'b0, 1, A1);           // R4 R7 R10 full compaction
        probe_pc(A2);                            // R8 kept hit
        // duplicates: lowest slot wins, removal picks matching kind
        do_cmd(2'd0, A2, 1'b1, 0, '0);
        do_cmd(2'd2, A2, 1'b0, 0, '0);           // R6 kept at lower slot
        do_cmd(2'd1, A2, 1'b1, 0, '0);           // R4 removes the once copy
        do_cmd(2'd2, A2, 1'b0, 0, '0);
        do_cmd(2'd0, A0, 1'b1, 0, '0);
        probe_pc(A0);                            // R9 once auto-removal
        probe_pc(A0);                            // R8 gone

        for (int it = 0; it < 400; it++) begin
            r = int'($urandom % 10);
            if (r < 4)       do_cmd(2'd0, pick(int'($urandom % 5)), 1'($urandom), 0, '0);
            else if (r < 6)  do_cmd(2'd1, pick(int'($urandom % 5)), 1'($urandom), 0, '0);
            else if (r < 8)  do_cmd(2'd2, pick(int'($urandom % 5)), 1'b0, 0, '0);
            else             probe_pc(pick(int'($urandom % 5)));
        end
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL R11 watchdog act=%0d exp=%0d", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

endmodule